// File: doc/BRIEF.md
# Pipelined CORDIC Vectoring Engine

This block measures the polar form of a signed fixed-point vector. A pair (x, y) is applied with a valid strobe. The engine first folds the vector into the right half-plane. It then passes the vector through a chain of shift-and-add iteration stages, each of which turns the vector toward the positive x axis. At the end of the chain, the x lane holds the vector length and the angle lane holds the total rotation applied, which is the four-quadrant arctangent of y over x.

Every stage is a pipeline register, so a new vector can enter on every clock. The stage count is a parameter: more stages give a finer angle at the cost of more adders and registers. The angle constants for each stage are computed during elaboration from the stage index and the angle width. The length output is not divided by the CORDIC gain. It comes out about 1.647 times the true length, and any downstream scaling is left to the consumer.

Top module: `cordic_vec`

## Requirements
- R1: A vector accepted with `in_valid` high appears on the outputs with `out_valid` high exactly STAGES+1 clocks later. A new vector can be accepted every clock, and idle cycles (`in_valid` low) come out as cycles with `out_valid` low in the same positions.
- R2: Before the iterations, a vector with x < 0 is folded into the right half-plane. If y >= 0, the engine sets (x, y) := (y, -x) and starts the angle at +pi/2. If y < 0, it sets (x, y) := (-y, x) and starts the angle at -pi/2. A vector with x >= 0 passes unchanged and starts the angle at 0.
- R3: At stage i (i = 0 .. STAGES-1), the direction is +1 when the current y is non-negative and -1 otherwise. The stage adds direction*atan(2^-i) to the angle.
- R4: At stage i, x becomes x + d*(y >>> i) and y becomes y - d*(x >>> i). Here >>> is an arithmetic right shift that rounds toward minus infinity, and no multiplier is used.
- R5: The angle is two's complement, ANG_W bits wide, with 2^(ANG_W-1) standing for pi and pi/2 encoded as 2^(ANG_W-2). Each stage constant is round(atan(2^-i)/pi * 2^(ANG_W-1)), and the angle sum wraps modulo 2^ANG_W. With the default parameters, input (1000, 0) yields magnitude 1641 and angle -496.
- R6: The magnitude output is DATA_W+2 bits, signed, and carries no gain correction. It is never negative for any input, including (-2^(DATA_W-1), -2^(DATA_W-1)).
- R7: A synchronous active-high reset clears every valid flag in the pipeline. `out_valid` is low while reset is high and on the first clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input vector is valid this cycle |
| in_x | input | DATA_W | Input x component, two's complement |
| in_y | input | DATA_W | Input y component, two's complement |
| out_valid | output | 1 | Result is valid this cycle |
| out_mag | output | DATA_W+2 | Unscaled vector length, two's complement |
| out_ang | output | ANG_W | Vector angle, 2^(ANG_W-1) = pi |

## Verification
The hardest situations to reach are at the quadrant fold boundaries and the extremes of the input range. These include x = -1 with y = 0 or y = -1, a vector lying on the negative x axis, and the most negative x and y together. In those cases a negation needs the guard bits, and the angle sum wraps past +pi. The stimulus applies these vectors directly, both back to back and with idle gaps in between. It then runs a long stream of random vectors under a random valid pattern, so every stage sees both directions and neighbouring bubbles. A behavioural model running the same iteration on integers predicts every output cycle.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

    // Extra integer bits in the x/y lanes to hold fold growth and CORDIC gain
    localparam int unsigned CORDIC_GUARD = 2;

    // Half-plane classification of an incoming vector
    typedef enum logic [1:0] {
        QUAD_RIGHT      = 2'd0,
        QUAD_UPPER_LEFT = 2'd1,
        QUAD_LOWER_LEFT = 2'd2
    } quad_e;

    // Rounded arctan(2^-idx) in an angle code where 2^(ang_w-1) is pi
    function automatic longint atan_code(input int unsigned idx, input int unsigned ang_w);
        real ratio;
        real scaled;
        ratio  = $atan(1.0 / (2.0 ** idx)) / 3.14159265358979323846;
        scaled = ratio * (2.0 ** (ang_w - 1));
        return longint'($floor(scaled + 0.5));
    endfunction

    // Classify the input vector for the pre-rotation stage
    function automatic quad_e classify(input logic x_neg, input logic y_neg);
        if (!x_neg)
            return QUAD_RIGHT;
        else if (!y_neg)
            return QUAD_UPPER_LEFT;
        else
            return QUAD_LOWER_LEFT;
    endfunction

endpackage

// File: rtl/cordic_prerot.sv
module cordic_prerot #(
    parameter int unsigned DW = 12,
    parameter int unsigned IW = 14,
    parameter int unsigned AW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 vld_i,
    input  logic signed [DW-1:0] x_i,
    input  logic signed [DW-1:0] y_i,
    output logic                 vld_o,
    output logic signed [IW-1:0] x_o,
    output logic signed [IW-1:0] y_o,
    output logic signed [AW-1:0] z_o
);
    import cordic_pkg::*;

    localparam logic signed [AW-1:0] HALF_PI = AW'(longint'(1) <<< (AW - 2));

    logic signed [IW-1:0] x_ext;
    logic signed [IW-1:0] y_ext;
    logic signed [IW-1:0] x_nxt;
    logic signed [IW-1:0] y_nxt;
    logic signed [AW-1:0] z_nxt;
    quad_e                quad;

    assign x_ext = {{(IW-DW){x_i[DW-1]}}, x_i};
    assign y_ext = {{(IW-DW){y_i[DW-1]}}, y_i};
    assign quad  = classify(x_i[DW-1], y_i[DW-1]);

    always_comb begin
        unique case (quad)
            QUAD_UPPER_LEFT: begin
                x_nxt = y_ext;
                y_nxt = -x_ext;
                z_nxt = HALF_PI;
            end
            QUAD_LOWER_LEFT: begin
                x_nxt = -y_ext;
                y_nxt = x_ext;
                z_nxt = -HALF_PI;
            end
            default: begin
                x_nxt = x_ext;
                y_nxt = y_ext;
                z_nxt = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) vld_o <= 1'b0;
        else     vld_o <= vld_i;
        x_o <= x_nxt;
        y_o <= y_nxt;
        z_o <= z_nxt;
    end

endmodule

// File: rtl/cordic_pe.sv
module cordic_pe #(
    parameter int unsigned IW    = 14,
    parameter int unsigned AW    = 16,
    parameter int unsigned SHIFT = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 vld_i,
    input  logic signed [IW-1:0] x_i,
    input  logic signed [IW-1:0] y_i,
    input  logic signed [AW-1:0] z_i,
    output logic                 vld_o,
    output logic signed [IW-1:0] x_o,
    output logic signed [IW-1:0] y_o,
    output logic signed [AW-1:0] z_o
);
    import cordic_pkg::*;

    localparam longint               ATAN_FULL = atan_code(SHIFT, AW);
    localparam logic signed [AW-1:0] ATAN      = ATAN_FULL[AW-1:0];

    logic signed [IW-1:0] x_sh;
    logic signed [IW-1:0] y_sh;
    logic signed [IW-1:0] x_nxt;
    logic signed [IW-1:0] y_nxt;
    logic signed [AW-1:0] z_nxt;
    logic                 turn_cw;

    assign x_sh    = x_i >>> SHIFT;
    assign y_sh    = y_i >>> SHIFT;
    assign turn_cw = ~y_i[IW-1];

    always_comb begin
        if (turn_cw) begin
            x_nxt = x_i + y_sh;
            y_nxt = y_i - x_sh;
            z_nxt = z_i + ATAN;
        end else begin
            x_nxt = x_i - y_sh;
            y_nxt = y_i + x_sh;
            z_nxt = z_i - ATAN;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) vld_o <= 1'b0;
        else     vld_o <= vld_i;
        x_o <= x_nxt;
        y_o <= y_nxt;
        z_o <= z_nxt;
    end

endmodule

// File: rtl/cordic_vec.sv
module cordic_vec #(
    parameter int unsigned DATA_W = 12,
    parameter int unsigned ANG_W  = 16,
    parameter int unsigned STAGES = 4
) (
    input  logic                                           clk,
    input  logic                                           rst,
    input  logic                                           in_valid,
    input  logic signed [DATA_W-1:0]                       in_x,
    input  logic signed [DATA_W-1:0]                       in_y,
    output logic                                           out_valid,
    output logic signed [DATA_W+cordic_pkg::CORDIC_GUARD-1:0] out_mag,
    output logic signed [ANG_W-1:0]                        out_ang
);
    import cordic_pkg::*;

    localparam int unsigned IW = DATA_W + CORDIC_GUARD;

    // Pipeline taps: index 0 is the pre-rotation output, index k the k-th stage output
    logic                    v_p [0:STAGES];
    logic signed [IW-1:0]    x_p [0:STAGES];
    logic signed [IW-1:0]    y_p [0:STAGES];
    logic signed [ANG_W-1:0] z_p [0:STAGES];

    cordic_prerot #(
        .DW (DATA_W),
        .IW (IW),
        .AW (ANG_W)
    ) u_prerot (
        .clk   (clk),
        .rst   (rst),
        .vld_i (in_valid),
        .x_i   (in_x),
        .y_i   (in_y),
        .vld_o (v_p[0]),
        .x_o   (x_p[0]),
        .y_o   (y_p[0]),
        .z_o   (z_p[0])
    );

    for (genvar k = 0; k < STAGES; k++) begin : g_pe
        cordic_pe #(
            .IW    (IW),
            .AW    (ANG_W),
            .SHIFT (k)
        ) u_pe (
            .clk   (clk),
            .rst   (rst),
            .vld_i (v_p[k]),
            .x_i   (x_p[k]),
            .y_i   (y_p[k]),
            .z_i   (z_p[k]),
            .vld_o (v_p[k+1]),
            .x_o   (x_p[k+1]),
            .y_o   (y_p[k+1]),
            .z_o   (z_p[k+1])
        );
    end

    assign out_valid = v_p[STAGES];
    assign out_mag   = x_p[STAGES];
    assign out_ang   = z_p[STAGES];

endmodule

// File: rtl/cordic_vec_chk.sv
module cordic_vec_chk #(
    parameter int unsigned IW     = 14,
    parameter int unsigned STAGES = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 out_valid,
    input logic signed [IW-1:0] out_mag,
    input logic                 pre_valid,
    input logic signed [IW-1:0] pre_x
);
    localparam int unsigned LAT = STAGES + 1;
    localparam int unsigned CW  = $clog2(LAT + 2);

    logic [LAT-1:0] shadow;
    logic [CW-1:0]  inflight;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow   <= '0;
            inflight <= '0;
        end else begin
            shadow   <= {shadow[LAT-2:0], in_valid};
            inflight <= inflight + CW'(in_valid) - CW'(out_valid);
        end
    end

    assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid == shadow[LAT-1]);

    assert_occupancy_R1: assert property (@(posedge clk) disable iff (rst)
        inflight <= CW'(LAT));

    assert_fold_right_R2: assert property (@(posedge clk) disable iff (rst)
        pre_valid |-> (pre_x >= 0));

    assert_mag_nonneg_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_mag >= 0));

    assert_reset_clear_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !out_valid);

endmodule

bind cordic_vec cordic_vec_chk #(
    .IW     (DATA_W + cordic_pkg::CORDIC_GUARD),
    .STAGES (STAGES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_mag   (out_mag),
    .pre_valid (v_p[0]),
    .pre_x     (x_p[0])
);

// File: tb/tb_cordic_vec.sv
module tb_cordic_vec;
    localparam int DW  = 12;
    localparam int AW  = 16;
    localparam int NS  = 4;
    localparam int IW  = DW + 2;
    localparam int LAT = NS + 1;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_x = '0;
    logic signed [DW-1:0] in_y = '0;
    logic                 out_valid;
    logic signed [IW-1:0] out_mag;
    logic signed [AW-1:0] out_ang;

    cordic_vec #(.DATA_W(DW), .ANG_W(AW), .STAGES(NS)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
        .out_valid(out_valid), .out_mag(out_mag), .out_ang(out_ang)
    );

    always #4 clk = ~clk;

    typedef struct {
        bit v;
        bit folded;
        int m;
        int a;
        int ix;
        int iy;
    } exp_t;

    exp_t q[$];
    int   atab[NS];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic exp_t model(input bit v, input int x0, input int y0);
        exp_t e;
        int x, y, z, nx, ny;
        e.v = v; e.ix = x0; e.iy = y0;
        e.folded = (x0 < 0);
        if (x0 < 0 && y0 >= 0) begin
            x = y0; y = -x0; z = 1 << (AW - 2);
        end else if (x0 < 0) begin
            x = -y0; y = x0; z = -(1 << (AW - 2));
        end else begin
            x = x0; y = y0; z = 0;
        end
        for (int i = 0; i < NS; i++) begin
            if (y >= 0) begin
                nx = x + (y >>> i); ny = y - (x >>> i); z = z + atab[i];
            end else begin
                nx = x - (y >>> i); ny = y + (x >>> i); z = z - atab[i];
            end
            x = nx; y = ny;
        end
        e.m = x; e.a = z;
        return e;
    endfunction

    // Sample at the falling edge, then drive the next input
    task automatic step(input bit v, input int x0, input int y0);
        exp_t e;
        bit [AW-1:0] ea;
        @(negedge clk);
        e = q.pop_front();
        chk(out_valid == e.v, "R1", "out_valid", int'(out_valid), int'(e.v));
        if (e.v && out_valid) begin
            ea = e.a[AW-1:0];
            chk(int'(out_mag) == e.m, "R4", "magnitude", int'(out_mag), e.m);
            if (e.folded)
                chk($unsigned(out_ang) == ea, "R2", "folded angle", int'($unsigned(out_ang)), int'(ea));
            else
                chk($unsigned(out_ang) == ea, "R3", "angle", int'($unsigned(out_ang)), int'(ea));
            chk(out_mag >= 0, "R6", "magnitude sign", int'(out_mag), e.m);
            if (e.ix == 1000 && e.iy == 0) begin
                chk(int'(out_mag) == 1641, "R5", "worked magnitude", int'(out_mag), 1641);
                chk(int'(out_ang) == -496, "R5", "worked angle", int'(out_ang), -496);
            end
        end
        in_valid = v;
        in_x = DW'(x0);
        in_y = DW'(y0);
        q.push_back(model(v, x0, y0));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NS; i++)
            atab[i] = int'($floor($atan(1.0 / (2.0 ** i)) / 3.14159265358979323846 * (2.0 ** (AW - 1)) + 0.5));

        // R7: valid stays low while reset is held
        repeat (3) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R7", "out_valid in reset", int'(out_valid), 0);
        end
        in_valid = 1'b1; in_x = 12'sd100; in_y = 12'sd100;
        @(negedge clk);
        chk(out_valid == 1'b0, "R7", "out_valid in reset with input", int'(out_valid), 0);
        in_valid = 1'b0;
        rst = 1'b0;
        for (int i = 0; i < LAT; i++) q.push_back(model(0, 0, 0));

        // Directed corners, back to back
        step(1, 1000, 0);
        step(1, -2048, 0);
        step(1, -1, 0);
        step(1, -1, -1);
        step(1, -2048, -2048);
        step(1, 0, -2048);
        step(1, 2047, 2047);
        step(1, 0, 0);
        step(1, 5, -5);
        step(1, -2048, 2047);
        // Same corners with bubbles between them
        step(0, 777, 777);
        step(1, -2048, -1);
        step(0, 0, 0);
        step(0, -5, 3);
        step(1, 1000, 0);
        step(1, -300, 1);
        for (int i = 0; i < LAT + 2; i++) step(0, 0, 0);

        // Random stream with random valid pattern (R1..R6)
        for (int n = 0; n < 3000; n++)
            step(($urandom_range(3) != 0), int'($urandom_range(4095)) - 2048, int'($urandom_range(4095)) - 2048);
        for (int i = 0; i < LAT + 1; i++) step(0, 0, 0);

        // R7: mid-stream reset flushes the pipeline
        step(1, 123, -456);
        step(1, -789, 321);
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        chk(out_valid == 1'b0, "R7", "out_valid after mid-stream reset", int'(out_valid), 0);
        @(negedge clk);
        chk(out_valid == 1'b0, "R7", "out_valid first cycle after release", int'(out_valid), 0);

        finish_run();
    end

endmodule